// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block supervises software by counting oscillator clocks while it is armed. A programmable divider turns the clock into slow ticks. Each tick advances a free-running counter, 16 bits wide by default. If software fails to restart the counter before it wraps past all-ones, the block issues a one-cycle reset pulse for the rest of the chip. The pulse is also applied to the block itself: it disarms the watchdog and records that the last reset came from the watchdog.

Software reaches the block through a small byte-wide register port. Writes take effect at the clock edge and reads return data combinationally. A control register arms the watchdog, picks the divider and carries a restart command. A status register holds the sticky watchdog-reset flag and a level that asks the address-latch pin driver to stay quiet, which reduces emissions. The external hardware reset is asserted asynchronously and released synchronously, and it clears every register in the block.

Top module: `wdg_top`

## Requirements
- R1: While the hardware reset is held, and after it is released, every register reads 0x00, the reset pulse is low and the inhibit output is low.
- R2: The control register is at address 0x9F. Bit 7 arms the watchdog and bits 2..0 hold the divider code. Bit 5 is a restart command that always reads 0. Bits 6, 4 and 3 read 0 and ignore writes, so writing 0xFF reads back 0x87. Any other address reads 0x00.
- R3: Divider code c gives one counter increment every 8<<c clocks. With the code set in the same write that arms the watchdog, the reset pulse appears (8<<c)*2^CNT_W clock edges after that write's edge.
- R4: The reset pulse lasts exactly one cycle. It appears on the clock after the cycle in which the counter wraps.
- R5: A watchdog reset clears the control register and the inhibit bit, and sets bit 7 of the status register. After the pulse, the control register reads 0x00 and the status register reads 0x80.
- R6: Writing 1 to control bit 5 zeroes both the divider count and the counter, so a full period starts at that write. A restart written in the same cycle as a wrap wins: no pulse follows.
- R7: While the watchdog is disarmed, the divider and the counter stay at zero and no pulse occurs, for any divider code.
- R8: A new divider code written while the watchdog is armed takes effect from the next divider terminal count. With code 0 armed at edge 0 and code 1 written at edge 3, the pulse comes at edge 8+16*(2^CNT_W-1).
- R9: The status flag (bit 7 at 0xBF) survives the watchdog reset. Software can clear it only by writing 0 to it; writing 1 has no effect. The hardware reset also clears it. A wrap in the same cycle as a software clear leaves the flag at 1.
- R10: Status bit 0 is read/write and drives the inhibit output level directly. Status bits 6..1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | External hardware reset, active low, asynchronous assert |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Read data for sfr_addr_i |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |
| ale_inhibit_o | output | 1 | Request to keep the address-latch pin quiet |

## Verification
Two pairs of events can fall in the same cycle. A restart write can coincide with the counter wrapping, and a software write that clears the status flag can coincide with the wrap that sets it. The bench arms the watchdog, counts exactly to the cycle before the pulse edge, and places the write there. It then judges the pulse and the status read against a cycle-level model built from the requirements. A long random phase mixes restarts, code changes and status writes so that these coincidences also occur without being arranged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // control register bit positions (decoded by software)
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned CLR_BIT  = 5;
  // status register bit positions
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned ALE_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } sel_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned PS_W      = 3,
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int unsigned PRE_W = BASE_LOG2 + (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PS_W-1:0]  ps_act_q, ps_act_d;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] term;
  logic             reload;

  always_comb begin
    span   = (PRE_W+1)'(1) << ((PRE_W+1)'(BASE_LOG2) + (PRE_W+1)'(ps_act_q));
    term   = PRE_W'(span - (PRE_W+1)'(1));
    tick_o = en_i && (pre_q == term);
    reload = !en_i || restart_i || tick_o;
    pre_d    = reload ? '0 : pre_q + PRE_W'(1);
    ps_act_d = reload ? ps_i : ps_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      ps_act_q <= '0;
    end else begin
      pre_q    <= pre_d;
      ps_act_q <= ps_act_d;
    end
  end

  // R7: divider count held at zero while disarmed
  assert_pre_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap_o = tick_i && (&cnt_q);
    if (!en_i || restart_i) cnt_d = '0;
    else if (tick_i)        cnt_d = cnt_q + CNT_W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: counter moves only on a divider tick
  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && !tick_i) |=> $stable(cnt_q));
  // R7: counter held at zero while disarmed
  assert_cnt_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PS_W      = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h9F,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              ovf_i,
  output logic              en_o,
  output logic [PS_W-1:0]   ps_next_o,
  output logic              clr_o,
  output logic              ale_o,
  output logic              pulse_o,
  output logic [7:0]        rdata_o
);
  sel_e            sel;
  logic            ctrl_we, stat_we;
  logic            en_q, en_d, ale_q, ale_d, flag_q, flag_d, pulse_q, pulse_d;
  logic [PS_W-1:0] ps_q, ps_d;

  always_comb begin
    if (addr_i == CTRL_ADDR)      sel = SEL_CTRL;
    else if (addr_i == STAT_ADDR) sel = SEL_STAT;
    else                          sel = SEL_NONE;
    ctrl_we = wr_i && (sel == SEL_CTRL);
    stat_we = wr_i && (sel == SEL_STAT);
    clr_o   = ctrl_we && wdata_i[CLR_BIT];
  end

  always_comb begin
    en_d    = en_q;
    ps_d    = ps_q;
    ale_d   = ale_q;
    flag_d  = flag_q;
    pulse_d = ovf_i;
    if (ovf_i) begin
      en_d   = 1'b0;
      ps_d   = '0;
      ale_d  = 1'b0;
      flag_d = 1'b1;
    end else begin
      if (ctrl_we) begin
        en_d = wdata_i[EN_BIT];
        ps_d = wdata_i[PS_W-1:0];
      end
      if (stat_we) begin
        ale_d = wdata_i[ALE_BIT];
        if (!wdata_i[FLAG_BIT]) flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ps_q    <= '0;
      ale_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      ps_q    <= ps_d;
      ale_q   <= ale_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: begin
        rdata_o[EN_BIT]     = en_q;
        rdata_o[PS_W-1:0]   = ps_q;
      end
      SEL_STAT: begin
        rdata_o[FLAG_BIT]   = flag_q;
        rdata_o[ALE_BIT]    = ale_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign ps_next_o = ps_d;
  assign ale_o     = ale_q;
  assign pulse_o   = pulse_q;

  // R4: pulse never lasts two cycles
  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  // R5: pulse coincides with a disarmed control and a set flag
  assert_reset_effect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (!en_q && flag_q && !ale_q && ps_q == '0));
  // R9: a wrap always leaves the flag set
  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PS_W      = 3,
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h9F,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  output logic              wdt_rst_o,
  output logic              ale_inhibit_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic            en, clr, tick, wrap, ovf;
  logic [PS_W-1:0] ps_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // a restart written in the wrap cycle cancels the wrap
  assign ovf = wrap && !clr;

  wdg_regs #(
    .ADDR_W(ADDR_W), .PS_W(PS_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(sfr_we_i), .addr_i(sfr_addr_i),
    .wdata_i(sfr_wdata_i), .ovf_i(ovf), .en_o(en), .ps_next_o(ps_next),
    .clr_o(clr), .ale_o(ale_inhibit_o), .pulse_o(wdt_rst_o), .rdata_o(sfr_rdata_o)
  );

  wdg_prescaler #(.PS_W(PS_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en), .restart_i(clr),
    .ps_i(ps_next), .tick_o(tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en), .restart_i(clr),
    .tick_i(tick), .wrap_o(wrap)
  );

  // R6: a restart never lets a pulse through on the next cycle
  assert_clear_beats_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr |=> !wdt_rst_o);
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  localparam int CW = 6;
  localparam logic [7:0] CA = 8'h9F;
  localparam logic [7:0] SA = 8'hBF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       pulse, ale;

  always #4 clk = ~clk;

  wdg_top #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(we), .sfr_addr_i(addr),
    .sfr_wdata_i(wd), .sfr_rdata_o(rd), .wdt_rst_o(pulse), .ale_inhibit_o(ale)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit m_en, m_ale, m_flag, m_pulse;
  int m_ps, m_psa, m_pre, m_cnt;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(logic [7:0] a);
    if (a == CA) return (int'(m_en) << 7) | m_ps;
    if (a == SA) return (int'(m_flag) << 7) | int'(m_ale);
    return 0;
  endfunction

  task automatic m_clear();
    m_en = 0; m_ale = 0; m_flag = 0; m_pulse = 0;
    m_ps = 0; m_psa = 0; m_pre = 0; m_cnt = 0;
  endtask

  task automatic m_step(bit w, logic [7:0] a, logic [7:0] d);
    bit cw = w && (a == CA);
    bit sw = w && (a == SA);
    bit clr = cw && d[5];
    bit tick = m_en && (m_pre == (8 << m_psa) - 1);
    bit ovf = tick && (m_cnt == (1 << CW) - 1) && !clr;
    bit restart = !m_en || clr || tick;
    if (ovf) begin
      m_en = 0; m_ps = 0; m_psa = 0; m_ale = 0; m_pre = 0; m_cnt = 0;
      m_flag = 1; m_pulse = 1;
      return;
    end
    m_pulse = 0;
    if (!m_en || clr) m_cnt = 0;
    else if (tick)    m_cnt = m_cnt + 1;
    m_pre = restart ? 0 : m_pre + 1;
    if (cw) begin m_en = d[7]; m_ps = int'(d[2:0]); end
    if (sw) begin m_ale = d[0]; if (!d[7]) m_flag = 0; end
    if (restart) m_psa = m_ps;
  endtask

  task automatic cyc(bit w, logic [7:0] a, logic [7:0] d, string tag);
    we = w; addr = a; wd = d;
    @(posedge clk); #1;
    m_step(w, a, d);
    we = 1'b0;
    chk({tag, " read"},  int'(rd),    m_read(a));
    chk({tag, " pulse"}, int'(pulse), int'(m_pulse));
    chk({tag, " ale"},   int'(ale),   int'(m_ale));
  endtask

  task automatic idle(int n, logic [7:0] a, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00, tag);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    m_clear();
    addr = CA; #1; chk("R1 ctrl in reset", int'(rd), 0);
    addr = SA; #1; chk("R1 stat in reset", int'(rd), 0);
    chk("R1 pulse in reset", int'(pulse), 0);
    chk("R1 ale in reset", int'(ale), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4, SA, "R1");
  endtask

  task automatic edges_to_pulse(string tag, output int n);
    n = 0;
    do begin
      cyc(1'b0, SA, 8'h00, tag);
      n++;
    end while (!pulse && n < 20000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    m_clear();
    hw_reset();
    cyc(1'b0, 8'h42, 8'h00, "R2 other addr");
    chk("R2 other addr zero", int'(rd), 0);

    // R2: field layout and unused bits
    cyc(1'b1, CA, 8'hFF, "R2");
    chk("R2 ctrl readback", int'(rd), 8'h87);
    cyc(1'b1, CA, 8'h00, "R2");
    chk("R2 ctrl cleared", int'(rd), 8'h00);

    // R7: disarmed for a long stretch with a code set
    cyc(1'b1, CA, 8'h05, "R7");
    for (int i = 0; i < 3000; i++) begin
      cyc(1'b0, CA, 8'h00, "R7");
      if (pulse) chk("R7 no pulse disarmed", 1, 0);
    end

    // R3 code 0
    cyc(1'b1, CA, 8'h80, "R3");
    edges_to_pulse("R3", n);
    chk("R3 period code 0", n, 8 * (1 << CW));
    // R4 / R5
    cyc(1'b0, CA, 8'h00, "R4");
    chk("R4 pulse single", int'(pulse), 0);
    chk("R5 ctrl after wd reset", int'(rd), 8'h00);
    cyc(1'b0, SA, 8'h00, "R5");
    chk("R5 stat after wd reset", int'(rd), 8'h80);

    // R9 / R10
    cyc(1'b1, SA, 8'h81, "R9");
    chk("R9 flag kept, ale set", int'(rd), 8'h81);
    chk("R10 ale out", int'(ale), 1);
    cyc(1'b1, SA, 8'h7F, "R10");
    chk("R10 flag cleared, bits 6..1 zero", int'(rd), 8'h01);

    // R3 code 2
    cyc(1'b1, CA, 8'h82, "R3");
    edges_to_pulse("R3", n);
    chk("R3 period code 2", n, 32 * (1 << CW));
    chk("R5 ale cleared by wd reset", int'(ale), 0);

    // R6: restart mid period
    cyc(1'b1, CA, 8'h80, "R6");
    idle(300, SA, "R6");
    cyc(1'b1, CA, 8'hA0, "R6");
    chk("R6 clear reads 0", int'(rd), 8'h80);
    edges_to_pulse("R6", n);
    chk("R6 full period after restart", n, 8 * (1 << CW));

    // R6: restart in the wrap cycle
    cyc(1'b1, CA, 8'h80, "R6");
    idle(8 * (1 << CW) - 1, SA, "R6");
    cyc(1'b1, CA, 8'hA0, "R6");
    chk("R6 restart beats wrap", int'(pulse), 0);
    edges_to_pulse("R6", n);
    chk("R6 period after coincident restart", n, 8 * (1 << CW));

    // R9: flag clear in the wrap cycle
    cyc(1'b1, SA, 8'h00, "R9");
    cyc(1'b1, CA, 8'h80, "R9");
    idle(8 * (1 << CW) - 1, SA, "R9");
    cyc(1'b1, SA, 8'h00, "R9");
    chk("R9 wrap wins over flag clear", int'(pulse), 1);
    chk("R9 flag set", int'(rd), 8'h80);

    // R8: code change while armed
    cyc(1'b1, CA, 8'h80, "R8");
    idle(2, SA, "R8");
    cyc(1'b1, CA, 8'h81, "R8");
    edges_to_pulse("R8", n);
    chk("R8 code change at terminal count", n + 3, 8 + 16 * ((1 << CW) - 1));

    // R9: hardware reset clears the flag
    hw_reset();
    cyc(1'b0, SA, 8'h00, "R9");
    chk("R9 flag cleared by hw reset", int'(rd), 8'h00);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      int r = int'($urandom() % 256);
      logic [7:0] a = (r < 128) ? CA : (r < 240) ? SA : 8'($urandom());
      if ($urandom() % 48 == 0) begin
        logic [7:0] d = 8'($urandom());
        if (a == CA) d = {1'b1, d[6], d[5] & d[4], d[4:2], 1'b0, d[0]};
        cyc(1'b1, a, d, "RND R3 R6 R8 R9");
      end else begin
        cyc(1'b0, a, 8'h00, "RND R2 R4 R10");
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule